// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Device Model

This block is a synthesizable model of the memory side of a quad-data-rate SRAM. It has a separate read port and write port, and every access moves a fixed burst of two words. The design runs on one fast system clock. The four device clock lines (K, K-bar, C, C-bar) arrive as ordinary inputs. The model samples them at the system clock and reacts to their rising transitions. A stopped clock therefore produces no transitions, and all state holds on its own. Each device clock level must stay stable for at least one system clock cycle, and no two device-clock rises may land in the same system cycle. C may lag K, but by less than half a K period.

A request is taken on a rising K. It carries a pair address, and the pair address names two adjacent words. The word address is `{pair, beat}`, so beat 0 is the even word and beat 1 is the odd word. A write stores beat 0 from the data input at that K rise and beat 1 at the following K-bar rise. A read returns beat 0 from the next cycle's C-bar rise and beat 1 from the C rise after that. If C and C-bar are both held high, K-bar and K take their place. An output-enable stands in for the three-state bus driver.

Top module: `qdr_b2_sram`

## Requirements
- R1: While reset is high, and after reset until a read burst starts, `q_oe` is 0.
- R2: A K rise with `wr_n`=0 stores `d` at word `{wr_pair,0}`. The next K-bar rise stores `d` at word `{wr_pair,1}`.
- R3: A read requested at K rise t puts word `{rd_pair,0}` on `q` with `q_oe`=1 from the C-bar rise of cycle t+1. It puts word `{rd_pair,1}` on `q` from the C rise of cycle t+2.
- R4: A read and a write requested at the same K rise use their own addresses, and neither disturbs the other.
- R5: A K rise with both selects at 1 writes nothing, whatever `d` and `wr_pair` hold, and starts no drive of the bus.
- R6: While `c` and `c_n` are both 1, the read beats of R3 follow the K-bar rise (beat 0) and the K rise (beat 1) instead.
- R7: A read returns the effects of every write requested at the same or an earlier K rise, and of none requested later.
- R8: Reads requested at consecutive K rises keep `q_oe` at 1 without a break across the boundary between bursts.
- R9: While no device clock line rises, `q` and `q_oe` hold their values.
- R10: After a burst's second beat, `q_oe` returns to 0 at the next beat-0 output edge when no read is due there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| k | input | 1 | Input clock K |
| k_n | input | 1 | Input clock K-bar |
| c | input | 1 | Output clock C |
| c_n | input | 1 | Output clock C-bar |
| rd_n | input | 1 | Read select, active low, taken on K rise |
| wr_n | input | 1 | Write select, active low, taken on K rise |
| rd_pair | input | PAIR_W | Read pair address |
| wr_pair | input | PAIR_W | Write pair address |
| d | input | DATA_W | Write data, both beats |
| q | output | DATA_W | Read data |
| q_oe | output | 1 | Read bus drive enable |

## Verification
In the bench, one K period is eight system cycles, and C lags K by one system cycle when it runs. Counted from the system edge that sees a read's K rise, beat 0 is valid from edge 12 (fallback) or 13 (C timing) for four edges. Beat 1 follows at edge 16 or 17. The bench therefore samples beat 0 at step 15 and beat 1 at step 19, which falls inside the valid window under both timings. The same steps fix the expected `q_oe`. Back-to-back bursts are also checked for drive at every step. For frozen clocks, the bench checks the outputs at every system cycle.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    localparam int unsigned QDR_DATA_W_DEF = 18;
    localparam int unsigned QDR_PAIR_W_DEF = 7;
    localparam int unsigned QDR_BEATS      = 2;
    localparam int unsigned QDR_NUM_LINES  = 4;

    // bit positions of the clock lines inside the line vector
    localparam int unsigned LN_K  = 0;
    localparam int unsigned LN_KN = 1;
    localparam int unsigned LN_C  = 2;
    localparam int unsigned LN_CN = 3;

    typedef enum logic {
        SRC_OUT_PAIR = 1'b0,
        SRC_IN_PAIR  = 1'b1
    } beat_src_e;

    typedef struct packed {
        logic first;
        logic second;
    } beat_evt_t;

    // both output clocks parked high selects the input pair as timing source
    function automatic beat_src_e pick_src(input logic c_lvl, input logic cn_lvl);
        return (c_lvl && cn_lvl) ? SRC_IN_PAIR : SRC_OUT_PAIR;
    endfunction

    function automatic beat_evt_t beat_events(input beat_src_e src,
                                              input logic [QDR_NUM_LINES-1:0] rise);
        beat_evt_t ev;
        if (src == SRC_IN_PAIR) begin
            ev.first  = rise[LN_KN];
            ev.second = rise[LN_K];
        end else begin
            ev.first  = rise[LN_CN];
            ev.second = rise[LN_C];
        end
        return ev;
    endfunction

endpackage

// File: rtl/qdr_edge_detect.sv
module qdr_edge_detect #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic prev;
        always_ff @(posedge clk) begin
            prev <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev;
    end

endmodule

// File: rtl/qdr_wr_port.sv
module qdr_wr_port #(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned PAIR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              k_rise,
    input  logic              kn_rise,
    input  logic              wr_n,
    input  logic [PAIR_W-1:0] wr_pair,
    input  logic [DATA_W-1:0] d,
    output logic [1:0]        we,
    output logic [PAIR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata
);

    logic              pend;
    logic [PAIR_W-1:0] pend_pair;

    always_comb begin
        we    = 2'b00;
        waddr = wr_pair;
        wdata = d;
        if (k_rise && !wr_n) begin
            we[0] = 1'b1;
        end else if (kn_rise && pend) begin
            we[1] = 1'b1;
            waddr = pend_pair;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_pair <= '0;
        end else if (k_rise) begin
            pend      <= !wr_n;
            pend_pair <= wr_pair;
        end else if (kn_rise) begin
            pend      <= 1'b0;
        end
    end

    // R2: the second beat is only armed by a write request on K
    a_r2_pend_from_request: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(k_rise && !wr_n));

endmodule

// File: rtl/qdr_pair_store.sv
module qdr_pair_store
    import qdr_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned PAIR_W = 7
) (
    input  logic                               clk,
    input  logic [QDR_BEATS-1:0]               we,
    input  logic [PAIR_W-1:0]                  waddr,
    input  logic [DATA_W-1:0]                  wdata,
    input  logic                               snap_en,
    input  logic [PAIR_W-1:0]                  raddr,
    output logic [QDR_BEATS-1:0][DATA_W-1:0]   snap
);

    localparam int unsigned DEPTH = 1 << PAIR_W;

    // one bank per beat: even words and odd words
    for (genvar b = 0; b < QDR_BEATS; b++) begin : g_bank
        logic [DATA_W-1:0] bank [DEPTH];
        always_ff @(posedge clk) begin
            if (we[b]) begin
                bank[waddr] <= wdata;
            end
            if (snap_en) begin
                snap[b] <= bank[raddr];
            end
        end
    end

endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe
    import qdr_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned PAIR_W = 7
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             k_rise,
    input  logic                             rd_req,
    input  logic [PAIR_W-1:0]                rd_pair,
    input  logic                             first_evt,
    input  logic                             second_evt,
    input  logic [QDR_BEATS-1:0][DATA_W-1:0] snap,
    output logic                             snap_en,
    output logic [PAIR_W-1:0]                snap_pair,
    output logic [DATA_W-1:0]                q,
    output logic                             q_oe
);

    typedef struct packed {
        logic              vld;
        logic [PAIR_W-1:0] pair;
    } rd_slot_t;

    rd_slot_t          s1;
    logic              s2_vld;
    logic [DATA_W-1:0] hold1;
    logic              beat2;

    // the pair is copied out at the K rise after the request
    assign snap_en   = k_rise & s1.vld;
    assign snap_pair = s1.pair;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= '0;
            s2_vld <= 1'b0;
            hold1  <= '0;
            beat2  <= 1'b0;
            q      <= '0;
            q_oe   <= 1'b0;
        end else begin
            if (k_rise) begin
                s1.vld  <= rd_req;
                s1.pair <= rd_pair;
                s2_vld  <= s1.vld;
            end
            if (first_evt) begin
                if (s2_vld) begin
                    q     <= snap[0];
                    hold1 <= snap[1];
                    q_oe  <= 1'b1;
                    beat2 <= 1'b1;
                end else begin
                    q_oe  <= 1'b0;
                    beat2 <= 1'b0;
                end
            end else if (second_evt && beat2) begin
                q     <= hold1;
                beat2 <= 1'b0;
            end
        end
    end

    // R8: the bus stays driven while the second beat is still owed
    a_r8_driven_until_second: assert property (@(posedge clk) disable iff (rst)
        beat2 |-> q_oe);

    // R10: drive is released only at a beat-0 output edge
    a_r10_release_on_first: assert property (@(posedge clk) disable iff (rst)
        $fell(q_oe) |-> $past(first_evt));

endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
    import qdr_pkg::*;
#(
    parameter int unsigned DATA_W = QDR_DATA_W_DEF,
    parameter int unsigned PAIR_W = QDR_PAIR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              k,
    input  logic              k_n,
    input  logic              c,
    input  logic              c_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [PAIR_W-1:0] rd_pair,
    input  logic [PAIR_W-1:0] wr_pair,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic              q_oe
);

    logic [QDR_NUM_LINES-1:0]         lines;
    logic [QDR_NUM_LINES-1:0]         raw_rise;
    logic [QDR_NUM_LINES-1:0]         rise;
    beat_src_e                        src;
    beat_evt_t                        evt;
    logic [1:0]                       we;
    logic [PAIR_W-1:0]                waddr;
    logic [DATA_W-1:0]                wdata;
    logic                             snap_en;
    logic [PAIR_W-1:0]                snap_pair;
    logic [QDR_BEATS-1:0][DATA_W-1:0] snap;
    logic                             rd_req;

    always_comb begin
        lines        = '0;
        lines[LN_K]  = k;
        lines[LN_KN] = k_n;
        lines[LN_C]  = c;
        lines[LN_CN] = c_n;
    end

    qdr_edge_detect #(.N(QDR_NUM_LINES)) u_edges (
        .clk  (clk),
        .lvl  (lines),
        .rise (raw_rise)
    );

    assign rise   = raw_rise & {QDR_NUM_LINES{~rst}};
    assign src    = pick_src(c, c_n);
    assign evt    = beat_events(src, rise);
    assign rd_req = rise[LN_K] & ~rd_n;

    qdr_wr_port #(.DATA_W(DATA_W), .PAIR_W(PAIR_W)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .k_rise  (rise[LN_K]),
        .kn_rise (rise[LN_KN]),
        .wr_n    (wr_n),
        .wr_pair (wr_pair),
        .d       (d),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata)
    );

    qdr_pair_store #(.DATA_W(DATA_W), .PAIR_W(PAIR_W)) u_store (
        .clk     (clk),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .snap_en (snap_en),
        .raddr   (snap_pair),
        .snap    (snap)
    );

    qdr_rd_pipe #(.DATA_W(DATA_W), .PAIR_W(PAIR_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .k_rise     (rise[LN_K]),
        .rd_req     (rd_req),
        .rd_pair    (rd_pair),
        .first_evt  (evt.first),
        .second_evt (evt.second),
        .snap       (snap),
        .snap_en    (snap_en),
        .snap_pair  (snap_pair),
        .q          (q),
        .q_oe       (q_oe)
    );

    // R1: reset leaves the bus released
    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> !q_oe);

    // R9: with no clock line rising, the outputs do not move
    a_r9_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        !(|raw_rise) |=> ($stable(q) && $stable(q_oe)));

    // R3 / R6: read data changes only after a selected output edge
    a_r6_change_on_selected_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(q) |-> $past(evt.first || evt.second));

endmodule

// File: tb/qdr_b2_sram_test.sv
module qdr_b2_sram_test;

    localparam int DW = 18;
    localparam int PW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          k = 1'b0, k_n = 1'b1, c = 1'b0, c_n = 1'b1;
    logic          rd_n = 1'b1, wr_n = 1'b1;
    logic [PW-1:0] rd_pair = '0, wr_pair = '0;
    logic [DW-1:0] d = '0;
    logic [DW-1:0] q;
    logic          q_oe;

    int            n_chk = 0;
    int            n_err = 0;
    int            cyc = 0;
    bit            park = 1'b0;
    logic          kd = 1'b0;
    bit            rd_h [4];
    logic [DW-1:0] e0 [4];
    logic [DW-1:0] e1 [4];
    string         tg [4];
    logic [DW-1:0] shadow [1 << (PW+1)];

    qdr_b2_sram uut (
        .clk(clk), .rst(rst), .k(k), .k_n(k_n), .c(c), .c_n(c_n),
        .rd_n(rd_n), .wr_n(wr_n), .rd_pair(rd_pair), .wr_pair(wr_pair),
        .d(d), .q(q), .q_oe(q_oe)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // one system step of the device clocks; C lags K by one step unless parked
    task automatic drive_clk(input int p);
        logic nk;
        nk = (p < 4);
        k   = nk;
        k_n = !nk;
        if (park) begin
            c = 1'b1; c_n = 1'b1;
        end else begin
            c = kd; c_n = !kd;
        end
        kd = nk;
    endtask

    // one K period of 8 steps; checks the bursts of the two earlier cycles
    task automatic kcycle(input bit rd, input logic [PW-1:0] ra,
                          input bit wr, input logic [PW-1:0] wa,
                          input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                          input string tag);
        int  s, sp1, sp2;
        bit  h1, h2;
        s   = cyc % 4;
        sp1 = (cyc + 3) % 4;
        sp2 = (cyc + 2) % 4;
        h1  = rd_h[sp1];
        h2  = rd_h[sp2];
        if (wr) begin
            shadow[{wa, 1'b0}] = d0;
            shadow[{wa, 1'b1}] = d1;
        end
        rd_h[s] = rd;
        tg[s]   = tag;
        if (rd) begin
            e0[s] = shadow[{ra, 1'b0}];
            e1[s] = shadow[{ra, 1'b1}];
        end
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            if (h1 && h2)
                chk(q_oe === 1'b1, "R8 continuous drive", {17'd0, q_oe}, 18'd1);
            if (p == 3) begin
                chk(q_oe === h2, h2 ? tg[sp2] : (h1 ? "R10" : "R5 idle bus"),
                    {17'd0, q_oe}, {17'd0, h2});
                if (h2) chk(q === e1[sp2], {tg[sp2], " beat1"}, q, e1[sp2]);
            end
            if (p == 7) begin
                chk(q_oe === h1, h1 ? tg[sp1] : (h2 ? "R10" : "R5 idle bus"),
                    {17'd0, q_oe}, {17'd0, h1});
                if (h1) chk(q === e0[sp1], {tg[sp1], " beat0"}, q, e0[sp1]);
            end
            drive_clk(p);
            if (p == 0) begin
                rd_n = !rd; wr_n = !wr;
                rd_pair = ra; wr_pair = wa;
                d = d0;
            end
            if (p == 4) d = d1;
        end
        cyc++;
    endtask

    task automatic nop_cycles(input int cnt);
        for (int i = 0; i < cnt; i++)
            kcycle(1'b0, '0, 1'b0, '0, 18'h3ffff, 18'h15555, "R5");
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(q_oe === 1'b0, "R1 during reset", {17'd0, q_oe}, 18'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(q_oe === 1'b0, "R1 after reset", {17'd0, q_oe}, 18'd0);
    endtask

    task automatic t_fill();
        for (int a = 0; a < (1 << PW); a++)
            kcycle(1'b0, '0, 1'b1, a[PW-1:0], $urandom, $urandom, "R2");
        nop_cycles(2);
    endtask

    task automatic t_write_read();
        logic [PW-1:0] pa [6];
        for (int i = 0; i < 6; i++) begin
            pa[i] = PW'(i * 19 + 3);
            kcycle(1'b0, '0, 1'b1, pa[i], $urandom, $urandom, "R2");
        end
        for (int i = 0; i < 6; i++) begin
            kcycle(1'b1, pa[i], 1'b0, '0, '0, '0, "R2 R3 readback");
            nop_cycles(1);
        end
        nop_cycles(2);
    endtask

    task automatic t_same_cycle();
        kcycle(1'b1, 7'd5, 1'b1, 7'd9, $urandom, $urandom, "R4 read side");
        kcycle(1'b1, 7'd9, 1'b0, '0, '0, '0, "R4 write side");
        nop_cycles(2);
        kcycle(1'b1, 7'd20, 1'b1, 7'd20, 18'h0abcd, 18'h1dcba, "R7 same cycle");
        nop_cycles(2);
        kcycle(1'b1, 7'd21, 1'b0, '0, '0, '0, "R7 later write unseen");
        kcycle(1'b0, '0, 1'b1, 7'd21, 18'h2f00f, 18'h30ff0, "R7");
        nop_cycles(2);
        kcycle(1'b0, '0, 1'b1, 7'd22, 18'h11111, 18'h22222, "R7");
        kcycle(1'b1, 7'd22, 1'b0, '0, '0, '0, "R7 previous cycle");
        nop_cycles(2);
    endtask

    task automatic t_nop();
        kcycle(1'b0, '0, 1'b0, 7'd30, 18'h3c3c3, 18'h0f0f0, "R5");
        kcycle(1'b0, '0, 1'b0, 7'd30, 18'h12345, 18'h2bcde, "R5");
        kcycle(1'b0, '0, 1'b0, 7'd30, 18'h3ffff, 18'h00000, "R5");
        kcycle(1'b1, 7'd30, 1'b0, '0, '0, '0, "R5 no store on idle");
        nop_cycles(2);
    endtask

    task automatic t_back_to_back(input string tag);
        for (int i = 0; i < 6; i++)
            kcycle(1'b1, PW'(40 + i * 7), (i == 2), PW'(40 + 3 * 7),
                   $urandom, $urandom, tag);
        nop_cycles(3);
    endtask

    task automatic t_fallback();
        park = 1'b1;
        nop_cycles(2);
        kcycle(1'b0, '0, 1'b1, 7'd60, 18'h1a1a1, 18'h2b2b2, "R6");
        kcycle(1'b1, 7'd60, 1'b0, '0, '0, '0, "R6 read");
        nop_cycles(1);
        kcycle(1'b1, 7'd5, 1'b1, 7'd61, $urandom, $urandom, "R6 with write");
        kcycle(1'b1, 7'd61, 1'b0, '0, '0, '0, "R6");
        nop_cycles(2);
        t_back_to_back("R6 R8");
        park = 1'b0;
        nop_cycles(2);
    endtask

    task automatic hold_check(input int cnt);
        logic [DW-1:0] q0;
        logic          o0;
        q0 = q;
        o0 = q_oe;
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            chk(q === q0, "R9 data held", q, q0);
            chk(q_oe === o0, "R9 enable held", {17'd0, q_oe}, {17'd0, o0});
        end
    endtask

    task automatic t_freeze();
        kcycle(1'b1, 7'd70, 1'b0, '0, '0, '0, "R9 burst across stop");
        kcycle(1'b0, '0, 1'b0, '0, '0, '0, "R5");
        hold_check(20);
        nop_cycles(3);
        hold_check(10);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            rd_h[i] = 1'b0; e0[i] = '0; e1[i] = '0; tg[i] = "R3";
        end
        t_reset();
        t_fill();
        t_write_read();
        t_same_cycle();
        t_nop();
        t_back_to_back("R8 R3");
        t_fallback();
        t_freeze();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule